// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one channel of a programmable interval timer. A 16-bit down-counter runs from a slow counter clock and a gate input, and produces a single output waveform. A mode word picks one of six counting behaviours: interrupt on terminal count, retriggerable one-shot, rate generator, square wave, software-started strobe and gate-started strobe. The same word selects plain binary or four-digit decimal (BCD) counting. The initial count is written in one access through a separate port.

Everything runs on one system clock. The counter clock and the gate arrive already synchronous to it. Rising and falling events of the counter clock are found by comparing each sample with the one before. The gate is sampled on counter-clock rises. New counts are loaded, and the counter steps down, on counter-clock falls. A gate rising edge is caught in a latch, so a gate pulse that falls between two counter-clock edges still starts or restarts the count.

Top module: `ictr_channel`

## Requirements
- R1: After reset the output is high and nothing counts until a mode word and then a count are written.
- R2: A mode write sets the output at the next system clock with no counter-clock edge: low for mode 0, high for modes 1 to 5. It halts counting until a new count is written.
- R3: The gate level seen at a counter-clock rise enables stepping in modes 0, 2, 3 and 4. In mode 0, a low gate holds the count and the output.
- R4: A gate rising edge is latched and taken at the next counter-clock rise. In modes 1 and 5, a rising edge seen in the same system cycle as a counter-clock rise is taken by that rise, so loading happens at the fall that follows.
- R5: Loads and decrements happen only on counter-clock falls. In mode 0, with gate high, a count N makes the output go high at the (N+1)-th fall after the write (one fall loads, N falls step down), and the output stays high after the counter wraps.
- R6: A written count of 0 stands for 65536 in binary and 10000 in BCD.
- R7: Mode 1: a trigger loads the count, and the output is low for exactly N counter-clock periods.
- R8: Mode 2: the output is low for one period out of every N, and the counter reloads by itself.
- R9: Mode 3: the output is a square wave of period N, high for ceil(N/2) periods and low for floor(N/2).
- R10: In modes 2 and 3, a low gate drives the output high at the next system clock and stops counting. The next gate rising edge restarts the count from the initial value.
- R11: Modes 4 and 5 give one low strobe, one period long, when the count first reaches zero. Mode 4 starts on a count write. Mode 5 starts on a trigger. No strobe repeats after the counter wraps.
- R12: In BCD mode (mode-word decimal bit = 1) each of the four digits steps down from 0 to 9 with a borrow into the next digit.
- R13: Mode codes 6 and 7 behave as modes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tickClk | input | 1 | Counter clock, synchronous to clk |
| gateIn | input | 1 | Gate, synchronous to clk |
| modeWr | input | 1 | Mode-word write strobe |
| modeSel | input | 3 | Mode code 0..7 |
| bcdSel | input | 1 | 1 = decimal counting, 0 = binary |
| countWr | input | 1 | Initial-count write strobe |
| countVal | input | 16 | Initial count (0 = full range) |
| outLevel | output | 1 | Channel output |

## Verification
The critical coincidence is a gate rising edge that lands in the same system cycle as a counter-clock rise. In that cycle the trigger latch is being set and sampled at once. The bench raises both inputs together in the one-shot mode. A correct design loads at the very next fall, so the output is already low when that tick ends, rather than one period later. A second overlap is the gate falling between a counter-clock rise and the fall that would step the rate generator into its low period. The immediate force-high must win, and the bench checks that the output holds high while the gate stays low.

// File: rtl/ictr_pkg.sv
package ictr_pkg;

  typedef enum logic [2:0] {
    MD_TERM    = 3'd0,
    MD_ONESHOT = 3'd1,
    MD_RATE    = 3'd2,
    MD_SQUARE  = 3'd3,
    MD_SWSTB   = 3'd4,
    MD_HWSTB   = 3'd5
  } ictrMode_e;

  typedef struct packed {
    logic load;
    logic dec;
  } dpStb_t;

  // codes 6 and 7 fold onto the periodic modes
  function automatic ictrMode_e mapMode(input logic [2:0] sel);
    if (sel[2] && sel[1]) return ictrMode_e'({1'b0, sel[1:0]});
    return ictrMode_e'(sel);
  endfunction

endpackage

// File: rtl/ictr_datapath.sv
module ictr_datapath
  import ictr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bcdMode,
  input  logic             countWr,
  input  logic [CNT_W-1:0] countVal,
  input  dpStb_t           stb,
  output logic             cntIsOne,
  output logic             nxtIsOne,
  output logic             nxtHigh3
);

  localparam int DIGITS = CNT_W / 4;
  localparam logic [CNT_W-1:0] BIN_HALF_FULL = CNT_W'(1) << (CNT_W - 1);
  localparam logic [CNT_W-1:0] BCD_HALF_FULL = CNT_W'(5) << (CNT_W - 4);

  logic [CNT_W-1:0] cntQ, initQ;
  logic [CNT_W-1:0] decBin, decBcd, decVal;
  logic [CNT_W-1:0] halfBcd, halfVal, nextVal;
  logic [DIGITS:0]  borrow;

  assign decBin    = cntQ - CNT_W'(1);
  assign borrow[0] = 1'b1;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [3:0] dig;
    logic       upperOdd;
    assign dig = cntQ[4*g +: 4];
    assign decBcd[4*g +: 4] = borrow[g] ? ((dig == 4'd0) ? 4'd9 : dig - 4'd1) : dig;
    assign borrow[g+1] = borrow[g] && (dig == 4'd0);
    if (g == DIGITS - 1) begin : g_top
      assign upperOdd = 1'b0;
    end else begin : g_low
      assign upperOdd = initQ[4*(g+1)];
    end
    assign halfBcd[4*g +: 4] = {1'b0, initQ[4*g+1 +: 3]} + (upperOdd ? 4'd5 : 4'd0);
  end

  assign decVal = bcdMode ? decBcd : decBin;

  always_comb begin
    if (initQ == '0)  halfVal = bcdMode ? BCD_HALF_FULL : BIN_HALF_FULL;
    else if (bcdMode) halfVal = halfBcd;
    else              halfVal = {1'b0, initQ[CNT_W-1:1]};
  end

  always_comb begin
    if (stb.load)     nextVal = initQ;
    else if (stb.dec) nextVal = decVal;
    else              nextVal = cntQ;
  end

  assign cntIsOne = (cntQ == CNT_W'(1));
  assign nxtIsOne = (nextVal == CNT_W'(1));
  assign nxtHigh3 = (nextVal == '0) || (nextVal > halfVal);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntQ  <= '0;
      initQ <= '0;
    end else begin
      if (countWr) initQ <= countVal;
      if (stb.load || stb.dec) cntQ <= nextVal;
    end
  end

endmodule

// File: rtl/ictr_ctrl.sv
module ictr_ctrl
  import ictr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tickClk,
  input  logic       gateIn,
  input  logic       modeWr,
  input  logic [2:0] modeSel,
  input  logic       bcdSel,
  input  logic       countWr,
  input  logic       cntIsOne,
  input  logic       nxtIsOne,
  input  logic       nxtHigh3,
  output dpStb_t     stb,
  output logic       bcdMode,
  output logic       outLevel
);

  ictrMode_e modeQ;
  logic tickPrev, gatePrev, trigFF, trigSmp, gateSmp;
  logic loadPend, haveCnt, running, strobeArm, outQ;
  logic tickRise, tickFall, gateRise, act, periodic, levelMode, strobeNow;

  assign tickRise  = tickClk && !tickPrev;
  assign tickFall  = !tickClk && tickPrev;
  assign gateRise  = gateIn && !gatePrev;
  assign act       = tickFall && !modeWr && !countWr;
  assign periodic  = (modeQ == MD_RATE) || (modeQ == MD_SQUARE);
  assign levelMode = (modeQ == MD_TERM) || (modeQ == MD_SWSTB) || periodic;
  assign strobeNow = stb.dec && cntIsOne && strobeArm;

  always_comb begin
    stb = '0;
    if (act) begin
      unique case (modeQ)
        MD_TERM, MD_SWSTB: begin
          if (loadPend)                stb.load = 1'b1;
          else if (running && gateSmp) stb.dec  = 1'b1;
        end
        MD_ONESHOT, MD_HWSTB: begin
          if (trigSmp && haveCnt) stb.load = 1'b1;
          else if (running)       stb.dec  = 1'b1;
        end
        MD_RATE, MD_SQUARE: begin
          if (loadPend || (trigSmp && running)) stb.load = 1'b1;
          else if (running && gateSmp) begin
            if (cntIsOne) stb.load = 1'b1;
            else          stb.dec  = 1'b1;
          end
        end
        default: stb = '0;
      endcase
    end
  end

  // gate sampling and trigger latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tickPrev <= 1'b0;
      gatePrev <= 1'b0;
      trigFF   <= 1'b0;
      trigSmp  <= 1'b0;
      gateSmp  <= 1'b0;
    end else begin
      tickPrev <= tickClk;
      gatePrev <= gateIn;
      if (tickRise) gateSmp <= gateIn;
      if (modeWr) begin
        trigFF  <= 1'b0;
        trigSmp <= 1'b0;
      end else if (tickRise) begin
        trigSmp <= trigFF || gateRise;
        trigFF  <= 1'b0;
      end else if (gateRise) begin
        trigFF <= 1'b1;
      end
    end
  end

  // mode state and output
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeQ     <= MD_TERM;
      bcdMode   <= 1'b0;
      loadPend  <= 1'b0;
      haveCnt   <= 1'b0;
      running   <= 1'b0;
      strobeArm <= 1'b0;
      outQ      <= 1'b1;
    end else begin
      if (modeWr) begin
        modeQ     <= mapMode(modeSel);
        bcdMode   <= bcdSel;
        loadPend  <= 1'b0;
        haveCnt   <= 1'b0;
        running   <= 1'b0;
        strobeArm <= 1'b0;
        outQ      <= (mapMode(modeSel) != MD_TERM);
      end else if (countWr) begin
        haveCnt <= 1'b1;
        if (levelMode) loadPend <= 1'b1;
        if (modeQ == MD_TERM || modeQ == MD_SWSTB) running <= 1'b0;
        if (modeQ == MD_TERM) outQ <= 1'b0;
      end else if (act) begin
        if (stb.load) begin
          running   <= 1'b1;
          loadPend  <= 1'b0;
          strobeArm <= 1'b1;
        end
        unique case (modeQ)
          MD_TERM: if (stb.dec && cntIsOne) outQ <= 1'b1;
          MD_ONESHOT: begin
            if (stb.load)                   outQ <= 1'b0;
            else if (stb.dec && cntIsOne)   outQ <= 1'b1;
          end
          MD_RATE: begin
            if (stb.load)     outQ <= 1'b1;
            else if (stb.dec) outQ <= !nxtIsOne;
          end
          MD_SQUARE: if (stb.load || stb.dec) outQ <= nxtHigh3;
          MD_SWSTB, MD_HWSTB: begin
            outQ <= !strobeNow;
            if (strobeNow) strobeArm <= 1'b0;
          end
          default: outQ <= outQ;
        endcase
      end
      if (!modeWr && periodic && !gateIn) outQ <= 1'b1;
    end
  end

  assign outLevel = outQ;

endmodule

// File: rtl/ictr_channel.sv
module ictr_channel
  import ictr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tickClk,
  input  logic             gateIn,
  input  logic             modeWr,
  input  logic [2:0]       modeSel,
  input  logic             bcdSel,
  input  logic             countWr,
  input  logic [CNT_W-1:0] countVal,
  output logic             outLevel
);

  dpStb_t stb;
  logic   bcdMode, cntIsOne, nxtIsOne, nxtHigh3;

  ictr_ctrl ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tickClk  (tickClk),
    .gateIn   (gateIn),
    .modeWr   (modeWr),
    .modeSel  (modeSel),
    .bcdSel   (bcdSel),
    .countWr  (countWr),
    .cntIsOne (cntIsOne),
    .nxtIsOne (nxtIsOne),
    .nxtHigh3 (nxtHigh3),
    .stb      (stb),
    .bcdMode  (bcdMode),
    .outLevel (outLevel)
  );

  ictr_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bcdMode  (bcdMode),
    .countWr  (countWr),
    .countVal (countVal),
    .stb      (stb),
    .cntIsOne (cntIsOne),
    .nxtIsOne (nxtIsOne),
    .nxtHigh3 (nxtHigh3)
  );

endmodule

// File: rtl/ictr_channel_checker.sv
module ictr_channel_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tickClk,
  input logic       gateIn,
  input logic       modeWr,
  input logic [2:0] modeSel,
  input logic       countWr,
  input logic       outLevel
);

  logic       prevTick;
  logic [1:0] curMode;   // 0:term/oneshot 1:periodic 2:strobe
  logic       fallNow, stepLow;

  assign fallNow = prevTick && !tickClk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevTick <= 1'b0;
      curMode  <= 2'd0;
    end else begin
      prevTick <= tickClk;
      if (modeWr) begin
        if (modeSel[1] && (modeSel[2] || 1'b1) && modeSel != 3'd4 && modeSel != 3'd5)
          curMode <= 2'd1;
        else if (modeSel == 3'd4 || modeSel == 3'd5)
          curMode <= 2'd2;
        else
          curMode <= 2'd0;
      end
    end
  end

  assign stepLow = fallNow && !outLevel && !modeWr && !countWr;

  // R2: a mode write sets the output level at once
  a_r2_mode_write_level: assert property (@(posedge clk) disable iff (!rst_n)
    modeWr |=> (outLevel == ($past(modeSel) != 3'd0)));

  // R10: low gate in periodic modes forces the output high
  a_r10_gate_low_high: assert property (@(posedge clk) disable iff (!rst_n)
    (curMode == 2'd1 && !gateIn && !modeWr) |=> outLevel);

  // R11: a strobe lasts at most one counter-clock period
  a_r11_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    (curMode == 2'd2 && stepLow) |=> outLevel);

  // R5: the output moves only on a fall, a write or a low gate
  a_r5_out_moves_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(outLevel) |-> ($past(fallNow) || $past(modeWr) || $past(countWr) || $past(!gateIn)));

endmodule

bind ictr_channel ictr_channel_checker chk_i (.*);

// File: tb/ictr_channel_tb.sv
module ictr_channel_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tickClk = 1'b0;
  logic        gateIn = 1'b1;
  logic        modeWr = 1'b0;
  logic [2:0]  modeSel = 3'd0;
  logic        bcdSel = 1'b0;
  logic        countWr = 1'b0;
  logic [15:0] countVal = 16'd0;
  logic        outLevel;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  ictr_channel dut_i (
    .clk(clk), .rst_n(rst_n), .tickClk(tickClk), .gateIn(gateIn),
    .modeWr(modeWr), .modeSel(modeSel), .bcdSel(bcdSel),
    .countWr(countWr), .countVal(countVal), .outLevel(outLevel)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: outLevel=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    tickClk = 1'b1;
    @(negedge clk);
    tickClk = 1'b0;
    @(negedge clk);
  endtask

  task automatic tickN(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic tickGate();
    tickClk = 1'b1;
    gateIn  = 1'b1;
    @(negedge clk);
    tickClk = 1'b0;
    @(negedge clk);
  endtask

  task automatic setGate(input logic v);
    gateIn = v;
    @(negedge clk);
  endtask

  task automatic writeMode(input logic [2:0] m, input logic b);
    modeWr = 1'b1; modeSel = m; bcdSel = b;
    @(negedge clk);
    modeWr = 1'b0;
  endtask

  task automatic writeCount(input logic [15:0] v);
    countWr = 1'b1; countVal = v;
    @(negedge clk);
    countWr = 1'b0;
  endtask

  // tick len times, compare output after each tick with pat (MSB first)
  task automatic runPattern(input string req, input logic [31:0] pat, input int len);
    for (int i = 0; i < len; i++) begin
      tick();
      chk(req, outLevel, pat[len-1-i]);
    end
  endtask

  task automatic testReset();
    chk("R1 reset level", outLevel, 1'b1);
    tickN(3);
    chk("R1 idle after reset", outLevel, 1'b1);
  endtask

  task automatic testMode0();
    writeMode(3'd0, 1'b0);
    chk("R2 mode0 write low", outLevel, 1'b0);
    writeCount(16'd3);
    runPattern("R5 mode0 count 3", 32'b000111, 6);
    writeMode(3'd0, 1'b0);
    chk("R2 rewrite mode0 low", outLevel, 1'b0);
    runPattern("R2 halted without count", 32'b000, 3);
  endtask

  task automatic testMode0Gate();
    setGate(1'b0);
    writeCount(16'd2);
    runPattern("R3 gate low holds", 32'b00000, 5);
    setGate(1'b1);
    runPattern("R3 gate high resumes", 32'b01, 2);
  endtask

  task automatic testMode1();
    setGate(1'b0);
    writeMode(3'd1, 1'b0);
    chk("R2 mode1 write high", outLevel, 1'b1);
    writeCount(16'd3);
    runPattern("R4 no trigger no start", 32'b11, 2);
    setGate(1'b1);
    setGate(1'b0);
    runPattern("R7 one-shot 3", 32'b00011, 5);
    writeCount(16'd2);
    tickGate();
    chk("R4 same-cycle trigger", outLevel, 1'b0);
    runPattern("R7 one-shot 2", 32'b01, 2);
    setGate(1'b0);
  endtask

  task automatic testMode2();
    setGate(1'b1);
    writeMode(3'd2, 1'b0);
    writeCount(16'd3);
    runPattern("R8 rate 3", 32'b110110, 6);
    setGate(1'b0);
    chk("R10 gate low forces high", outLevel, 1'b1);
    runPattern("R10 halted while gate low", 32'b111, 3);
    setGate(1'b1);
    runPattern("R10 restart from initial", 32'b1101, 4);
  endtask

  task automatic testMode3();
    writeMode(3'd3, 1'b0);
    writeCount(16'd5);
    runPattern("R9 square odd 5", 32'b1110011100, 10);
    writeMode(3'd3, 1'b0);
    writeCount(16'd4);
    runPattern("R9 square even 4", 32'b11001100, 8);
    writeMode(3'd3, 1'b1);
    writeCount(16'h0014);
    runPattern("R12 bcd square 14", 32'b111111100000001111111, 21);
  endtask

  task automatic testStrobes();
    writeMode(3'd4, 1'b0);
    writeCount(16'd2);
    runPattern("R11 sw strobe", 32'b110111, 6);
    writeMode(3'd5, 1'b0);
    writeCount(16'd2);
    runPattern("R11 hw strobe waits", 32'b1, 1);
    setGate(1'b0);
    setGate(1'b1);
    runPattern("R11 hw strobe", 32'b11011, 5);
  endtask

  task automatic testAlias();
    writeMode(3'd6, 1'b0);
    chk("R13 code 6 level", outLevel, 1'b1);
    writeCount(16'd3);
    runPattern("R13 code 6 as rate", 32'b110110, 6);
    writeMode(3'd7, 1'b0);
    writeCount(16'd4);
    runPattern("R13 code 7 as square", 32'b11001100, 8);
  endtask

  task automatic testFullRange();
    writeMode(3'd0, 1'b1);
    writeCount(16'd0);
    tickN(10000);
    chk("R6 R12 bcd zero not done", outLevel, 1'b0);
    tick();
    chk("R6 R12 bcd zero = 10000", outLevel, 1'b1);
    writeMode(3'd0, 1'b0);
    writeCount(16'd0);
    tickN(65536);
    chk("R6 bin zero not done", outLevel, 1'b0);
    tick();
    chk("R6 bin zero = 65536", outLevel, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testMode0();
    testMode0Gate();
    testMode1();
    testMode2();
    testMode3();
    testStrobes();
    testAlias();
    testFullRange();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule